// File: doc/BRIEF.md
# Direction-Qualified Dual Compare Unit

The block sits beside a 16-bit up/down counter and holds two compare values. On every cycle in which the counter presents a freshly updated count, each compare value is checked against that count. A channel whose value matches emits a one-cycle interrupt pulse. The counter itself, its prescaler, any capture logic and the interrupt controller are outside the block.

The operating mode decides whether a match is also qualified by count direction. In plain timer mode, and in the first up/down sub-mode, every match fires. In the second up/down sub-mode, channel 0 fires only on matches reached while counting up, and channel 1 fires only on matches reached while counting down.

The compare values are set through a plain word-wide register port. The counter must be stopped for these writes to take effect. A write attempted while the counter runs is dropped and leaves a sticky error flag behind. No data stream crosses the block's edge, so there is no valid/ready handshake. Every pin is a plain control or status signal, and a write is taken on any rising edge where `reg_wr` is high.

Top module: `dual_cmp_unit`

## Requirements
- R1: After reset both compare registers read 0x0000, the error flag reads 0 and both `irq` bits are 0.
- R2: With `cnt_en`=0, a write to address 0 (channel 0) or address 1 (channel 1) replaces all 16 bits of that register. `reg_rdata` returns the stored value combinationally for the address on `reg_addr`. Address 3 reads 0.
- R3: When `cnt_upd`=1 and `cnt_val` equals a channel's compare value, and the mode allows it, that channel's `irq` bit is 1 for exactly the following cycle.
- R4: A cycle with `cnt_upd`=0 never produces a pulse, even when `cnt_val` equals a compare value. A counter that holds its value therefore yields one pulse only.
- R5: In timer mode (`mode_ctr`=0), every match fires on both channels, whatever the values of `cnt_up` and `mode_sel`.
- R6: In up/down sub-mode A (`mode_ctr`=1, `mode_sel`=0), every match fires regardless of `cnt_up`.
- R7: In up/down sub-mode B (`mode_ctr`=1, `mode_sel`=1), channel 0 fires only when `cnt_up`=1.
- R8: In sub-mode B, channel 1 fires only when `cnt_up`=0.
- R9: A write to address 0 or 1 while `cnt_en`=1 is ignored, and the register keeps its old value.
- R10: An ignored write sets the error flag, read as bit 0 at address 2 (other bits read 0). A write to address 2 with bit 0 = 1 clears the flag. A write there with bit 0 = 0 leaves it unchanged.
- R11: The direction is taken from `cnt_up` in the same cycle as the update that produces the match, not from an earlier cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current counter value |
| cnt_upd | input | 1 | Counter value was updated this cycle |
| cnt_up | input | 1 | Count direction: 1 up, 0 down |
| cnt_en | input | 1 | Counter enabled; blocks compare writes |
| mode_ctr | input | 1 | 0 timer mode, 1 up/down counter mode |
| mode_sel | input | 1 | Up/down sub-mode: 0 A, 1 B |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 2 | Interrupt pulses, bit n for channel n |

## Verification
Each interrupt is registered. Its result is therefore due in the cycle after the edge that samples `cnt_upd`, `cnt_val` and `cnt_up`. The bench drives each stimulus on a falling edge and checks `irq` on the next falling edge, which places exactly one rising edge in between. Register writes become visible on `reg_rdata` after the same single edge, and reads are checked a short delay after `reg_addr` changes, because the read path is combinational. The sweep covers every mode and direction combination over a range of counter values, and the expected pulses are computed arithmetically from the requirements.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  localparam int unsigned NCH = 2;
  localparam int unsigned AW  = 2;
  typedef enum logic [AW-1:0] {
    ADDR_CMP0 = 2'd0,
    ADDR_CMP1 = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dcu_regs.sv
module dcu_regs
  import dcu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          cnt_en,
  output logic [W-1:0]  cmp [NCH],
  output logic          werr,
  output logic [W-1:0]  rdata
);
  logic wr_cmp;
  assign wr_cmp = wr && (addr == ADDR_CMP0 || addr == ADDR_CMP1);

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cmp[i] <= '0;
      else if (wr && !cnt_en && addr == AW'(i))    cmp[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      werr <= 1'b0;
    else if (wr_cmp && cnt_en)                       werr <= 1'b1;
    else if (wr && addr == ADDR_STAT && wdata[0])    werr <= 1'b0;
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      ADDR_CMP0: rdata = cmp[0];
      ADDR_CMP1: rdata = cmp[1];
      ADDR_STAT: rdata = {{(W-1){1'b0}}, werr};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dcu_match.sv
module dcu_match #(
  parameter int unsigned W = 16,
  parameter bit QUAL_UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_upd,
  input  logic         cnt_up,
  input  logic         dir_qual,
  input  logic [W-1:0] cmp,
  output logic         irq
);
  logic hit, dir_ok;
  assign dir_ok = !dir_qual || (cnt_up == QUAL_UP);
  assign hit    = cnt_upd && (cnt_val == cmp) && dir_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end
endmodule

// File: rtl/dual_cmp_unit.sv
module dual_cmp_unit
  import dcu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt_val,
  input  logic          cnt_upd,
  input  logic          cnt_up,
  input  logic          cnt_en,
  input  logic          mode_ctr,
  input  logic          mode_sel,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic [NCH-1:0] irq
);
  logic [W-1:0] cmp [NCH];
  logic         werr;
  logic         dir_qual;

  assign dir_qual = mode_ctr && mode_sel;

  dcu_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cnt_en(cnt_en), .cmp(cmp), .werr(werr),
    .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dcu_match #(.W(W), .QUAL_UP(i == 0)) u_match (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
      .cnt_up(cnt_up), .dir_qual(dir_qual), .cmp(cmp[i]), .irq(irq[i])
    );
  end
endmodule

// File: rtl/dcu_chk.sv
module dcu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_val,
  input logic         cnt_upd,
  input logic         cnt_up,
  input logic         cnt_en,
  input logic         mode_ctr,
  input logic         mode_sel,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic [1:0]   irq,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic         werr
);
  // R3 / R4: a pulse needs an update and an equal value one cycle earlier
  assert_irq0_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> $past(cnt_upd && cnt_val == cmp0));
  assert_irq1_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> $past(cnt_upd && cnt_val == cmp1));
  assert_ch0_up_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[0] && $past(mode_ctr && mode_sel)) |-> $past(cnt_up));
  assert_ch1_down_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq[1] && $past(mode_ctr && mode_sel)) |-> !$past(cnt_up));
  assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && cnt_en && reg_addr < 2'd2) |=> ($stable(cmp0) && $stable(cmp1)));
  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(werr) |-> $past(reg_wr && cnt_en && reg_addr < 2'd2));
endmodule

bind dual_cmp_unit dcu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
  .cnt_up(cnt_up), .cnt_en(cnt_en), .mode_ctr(mode_ctr), .mode_sel(mode_sel),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .irq(irq),
  .cmp0(cmp[0]), .cmp1(cmp[1]), .werr(werr)
);

// File: tb/tb_dual_cmp_unit.sv
module tb_dual_cmp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        cnt_upd = 1'b0, cnt_up = 1'b0, cnt_en = 1'b0;
  logic        mode_ctr = 1'b0, mode_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_cmp_unit dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
    .cnt_up(cnt_up), .cnt_en(cnt_en), .mode_ctr(mode_ctr), .mode_sel(mode_sel),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic step(input string req, input logic upd, input logic [15:0] v,
                      input logic up, input logic [1:0] exp);
    cnt_upd = upd; cnt_val = v; cnt_up = up;
    @(negedge clk);
    chk(req, {14'd0, irq}, {14'd0, exp});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] c0, c1;
    c0 = 16'd17; c1 = 16'd40;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {14'd0, irq}, 16'd0);
    rd("R1 cmp0", 2'd0, 16'h0000);
    rd("R1 cmp1", 2'd1, 16'h0000);
    rd("R1 err", 2'd2, 16'h0000);
    // R2 full-word writes and readback
    wr(2'd0, 16'hA5C3); rd("R2 cmp0", 2'd0, 16'hA5C3);
    wr(2'd1, 16'h5A3C); rd("R2 cmp1", 2'd1, 16'h5A3C);
    rd("R2 addr3", 2'd3, 16'h0000);
    wr(2'd0, c0); wr(2'd1, c1);
    rd("R2 cmp0", 2'd0, c0); rd("R2 cmp1", 2'd1, c1);
    // R3 R5 R6 R7 R8 sweep over modes, directions, values
    for (int m = 0; m < 4; m++) begin
      mode_ctr = m[1]; mode_sel = m[0];
      for (int d = 0; d < 2; d++) begin
        for (int v = 0; v < 64; v++) begin
          logic b, e0, e1;
          b  = m[1] && m[0];
          e0 = (v == c0) && (!b || d == 1);
          e1 = (v == c1) && (!b || d == 0);
          step(m[1] ? (b ? "R7/R8 subB" : "R6 subA") : "R5 timer",
               1'b1, 16'(v), d[0], {e1, e0});
        end
      end
    end
    // R4 hold: one pulse, then none while held
    mode_ctr = 1'b0; mode_sel = 1'b0;
    step("R4 first", 1'b1, c0, 1'b1, 2'b01);
    step("R4 hold", 1'b0, c0, 1'b1, 2'b00);
    step("R4 hold", 1'b0, c0, 1'b1, 2'b00);
    step("R4 hold", 1'b0, c1, 1'b0, 2'b00);
    // R11 direction flips on the matching update
    mode_ctr = 1'b1; mode_sel = 1'b1;
    step("R11 pre", 1'b1, 16'd16, 1'b0, 2'b00);
    step("R11 ch0", 1'b1, c0, 1'b1, 2'b01);
    step("R11 pre", 1'b1, 16'd41, 1'b1, 2'b00);
    step("R11 ch1", 1'b1, c1, 1'b0, 2'b10);
    step("R11 pre", 1'b1, 16'd16, 1'b1, 2'b00);
    step("R11 ch0 blocked", 1'b1, c0, 1'b0, 2'b00);
    cnt_upd = 1'b0;
    // R9 R10 locked writes
    cnt_en = 1'b1;
    wr(2'd0, 16'h1234); rd("R9 cmp0 kept", 2'd0, c0);
    rd("R10 err set", 2'd2, 16'h0001);
    wr(2'd1, 16'h4321); rd("R9 cmp1 kept", 2'd1, c1);
    cnt_en = 1'b0;
    wr(2'd2, 16'h0000); rd("R10 write0 keeps", 2'd2, 16'h0001);
    wr(2'd2, 16'h0001); rd("R10 cleared", 2'd2, 16'h0000);
    wr(2'd0, 16'h0007); rd("R2 unlocked", 2'd0, 16'h0007);
    rd("R10 no err", 2'd2, 16'h0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule